// File: doc/BRIEF.md
# Prioritized Reference Clock Selector

This block chooses a primary and a secondary timing reference from up to eight candidate sources. Every candidate presents a signal-fail flag, a received quality rank, a configured quality rank, a priority, a kind (external input A, external input B or line), a slot number, and lockout and force requests. Global controls enable quality checking, choose whether ranking uses the configured or the received rank, pick revertive or non-revertive behaviour, and switch between free-run and automatic selection.

Candidates are ordered by quality, then priority, then incumbency, with the lowest index breaking any tie that remains. The choice is re-evaluated only on a tick input. The primary and secondary indices, their valid flags, the quality rank of the primary and a free-run flag are registered, and a one-cycle pulse marks every tick that changes the primary or the secondary. Quality ranks arrive as plain integers where a larger value is better and 0 is the do-not-use code.

Top module: `refclk_selector`

## Requirements
- R1: With quality mode on, the qualifying candidate with the largest ranking quality becomes primary.
- R2: Priority breaks quality ties (and is the only criterion with quality mode off): a configured priority 1..5 (1 strongest) beats every unconfigured one (value 0, 6 or 7); among unconfigured ones kind code 0 (external A) beats kind 1 (external B), which beats kind 2 or 3 (line).
- R3: On a tie in quality and priority the current holder of the role keeps it; otherwise the lowest index wins.
- R4: A candidate qualifies only when its signal-fail flag is low, it is not locked out and, with quality mode on, its received rank is at least its configured rank. With quality mode on, the selection-mode input picks the received rank (1) or the configured rank (0) for ranking.
- R5: A locked-out candidate is never primary or secondary.
- R6: When exactly one force request is set and that candidate has no signal fail and no lockout, it becomes primary regardless of ranking; two or more force requests are ignored.
- R7: In revertive mode the best qualifying candidate is taken on each tick; in non-revertive mode the current primary is kept for as long as it qualifies.
- R8: In free-run mode both valid flags are low, the quality output is 0 and the free-run flag is high, whatever the candidates present.
- R9: The secondary is the best qualifying candidate other than the primary whose slot bit 1 differs from that of the primary (slots 0 and 1 form one pair, 2 and 3 the other).
- R10: Outputs change only in the cycle after a tick; the update pulse is high for exactly that cycle when the primary or secondary index or valid flag changed.
- R11: When nothing qualifies, both valid flags are low and the quality output is 0; otherwise the quality output is the primary's ranking rank (configured rank when quality mode is off or the configured rank is selected).
- R12: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Re-evaluate the selection on this cycle |
| fail_i | input | N | Per-candidate signal fail |
| rxq_i | input | N*QW | Per-candidate received quality rank |
| cfgq_i | input | N*QW | Per-candidate configured quality rank |
| prio_i | input | N*3 | Per-candidate priority, 1..5 configured, else unconfigured |
| kind_i | input | N*2 | Per-candidate kind: 0 external A, 1 external B, 2/3 line |
| slot_i | input | N*2 | Per-candidate slot number |
| lock_i | input | N | Per-candidate lockout |
| force_i | input | N | Per-candidate force request |
| qmode_i | input | 1 | Quality mode enable |
| selrx_i | input | 1 | Rank on received (1) or configured (0) quality |
| revert_i | input | 1 | Revertive (1) or non-revertive (0) |
| freerun_i | input | 1 | Free-run (1) or automatic selection (0) |
| pri_idx_o | output | log2(N) | Primary index |
| pri_valid_o | output | 1 | Primary valid |
| sec_idx_o | output | log2(N) | Secondary index |
| sec_valid_o | output | 1 | Secondary valid |
| qual_o | output | QW | Quality rank of the primary, 0 when none |
| freerun_o | output | 1 | Free-run in effect |
| upd_o | output | 1 | One-cycle pulse when primary or secondary changed |

## Verification
The hardest state to reach is a genuine tie in which incumbency decides: two candidates must match in ranking quality and priority score while one of them already holds the role, so that the lowest-index rule and the keep-current rule give different answers. The stimulus builds that state in directed steps (enable one candidate, tick, then enable an identical lower-index one), and non-revertive holds are reached the same way by qualifying a better source only after a worse one has taken the primary. Random ticks with clustered quality and priority values then revisit ties often enough to check both roles against a bench model.

// File: rtl/rcs_pkg.sv
`timescale 1ns/1ps
package rcs_pkg;
    localparam int PRW  = 3;  // priority field width
    localparam int KDW  = 2;  // kind field width
    localparam int SLW  = 2;  // slot field width
    localparam int PSW  = 4;  // priority score width

    localparam logic [KDW-1:0] KIND_EXT_A = 2'd0;
    localparam logic [KDW-1:0] KIND_EXT_B = 2'd1;

    // Larger score wins. Configured 1..5 maps to 7..3, defaults to 2..0.
    function automatic logic [PSW-1:0] prio_score(input logic [PRW-1:0] p,
                                                  input logic [KDW-1:0] k);
        logic [PSW-1:0] s;
        if (p >= 3'd1 && p <= 3'd5) begin
            s = 4'd8 - {1'b0, p};
        end else if (k == KIND_EXT_A) begin
            s = 4'd2;
        end else if (k == KIND_EXT_B) begin
            s = 4'd1;
        end else begin
            s = 4'd0;
        end
        return s;
    endfunction
endpackage

// File: rtl/rcs_rank.sv
`timescale 1ns/1ps
module rcs_rank
    import rcs_pkg::*;
#(
    parameter int N  = 8,
    parameter int QW = 3,
    localparam int KW = QW + PSW
) (
    input  logic [N-1:0]     fail_i,
    input  logic [N-1:0]     lock_i,
    input  logic [N*QW-1:0]  rxq_i,
    input  logic [N*QW-1:0]  cfgq_i,
    input  logic [N*PRW-1:0] prio_i,
    input  logic [N*KDW-1:0] kind_i,
    input  logic             qmode_i,
    input  logic             selrx_i,
    output logic [N*KW-1:0]  key_o,
    output logic [N*QW-1:0]  qsel_o,
    output logic [N-1:0]     ok_o,
    output logic [N-1:0]     elig_o
);
    for (genvar g = 0; g < N; g++) begin : g_cand
        logic [QW-1:0] rx, cfg, qs, qr;
        always_comb begin
            rx  = rxq_i[g*QW +: QW];
            cfg = cfgq_i[g*QW +: QW];
            qs  = (qmode_i && selrx_i) ? rx : cfg;
            qr  = qmode_i ? qs : '0;
            elig_o[g] = !fail_i[g] && !lock_i[g];
            ok_o[g]   = elig_o[g] && (!qmode_i || (rx >= cfg));
            qsel_o[g*QW +: QW] = qs;
            key_o[g*KW +: KW]  = {qr, prio_score(prio_i[g*PRW +: PRW],
                                                 kind_i[g*KDW +: KDW])};
        end
    end
endmodule

// File: rtl/rcs_pick.sv
`timescale 1ns/1ps
module rcs_pick #(
    parameter int N  = 8,
    parameter int KW = 7,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N*KW-1:0] key_i,
    input  logic [N-1:0]    mask_i,
    input  logic            inc_valid_i,
    input  logic [IW-1:0]   inc_idx_i,
    output logic            found_o,
    output logic [IW-1:0]   idx_o
);
    // Incumbency is the least significant bit of the compared key; a strict
    // comparison in ascending order leaves the lowest index on full ties.
    logic [KW:0] best;
    logic [KW:0] cur;
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best    = '0;
        cur     = '0;
        for (int i = 0; i < N; i++) begin
            cur = {key_i[i*KW +: KW], inc_valid_i && (inc_idx_i == IW'(i))};
            if (mask_i[i] && (!found_o || cur > best)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                best    = cur;
            end
        end
    end
endmodule

// File: rtl/refclk_selector.sv
`timescale 1ns/1ps
module refclk_selector
    import rcs_pkg::*;
#(
    parameter int N  = 8,
    parameter int QW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1,
    localparam int KW = QW + PSW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [N-1:0]     fail_i,
    input  logic [N*QW-1:0]  rxq_i,
    input  logic [N*QW-1:0]  cfgq_i,
    input  logic [N*PRW-1:0] prio_i,
    input  logic [N*KDW-1:0] kind_i,
    input  logic [N*SLW-1:0] slot_i,
    input  logic [N-1:0]     lock_i,
    input  logic [N-1:0]     force_i,
    input  logic             qmode_i,
    input  logic             selrx_i,
    input  logic             revert_i,
    input  logic             freerun_i,
    output logic [IW-1:0]    pri_idx_o,
    output logic             pri_valid_o,
    output logic [IW-1:0]    sec_idx_o,
    output logic             sec_valid_o,
    output logic [QW-1:0]    qual_o,
    output logic             freerun_o,
    output logic             upd_o
);
    typedef struct packed {
        logic [IW-1:0] pi;
        logic          pv;
        logic [IW-1:0] si;
        logic          sv;
        logic [QW-1:0] q;
        logic          fr;
        logic          upd;
    } sel_st_t;

    sel_st_t st_d, st_q;

    logic [N*KW-1:0] key;
    logic [N*QW-1:0] qsel;
    logic [N-1:0]    ok, elig, pair, smask;

    rcs_rank #(.N(N), .QW(QW)) u_rank (
        .fail_i (fail_i),  .lock_i (lock_i),
        .rxq_i  (rxq_i),   .cfgq_i (cfgq_i),
        .prio_i (prio_i),  .kind_i (kind_i),
        .qmode_i(qmode_i), .selrx_i(selrx_i),
        .key_o  (key),     .qsel_o (qsel),
        .ok_o   (ok),      .elig_o (elig)
    );

    // Best qualifying primary candidate
    logic          best_f;
    logic [IW-1:0] best_i;
    rcs_pick #(.N(N), .KW(KW)) u_pick_pri (
        .key_i(key), .mask_i(ok),
        .inc_valid_i(st_q.pv), .inc_idx_i(st_q.pi),
        .found_o(best_f), .idx_o(best_i)
    );

    // Force request: honoured only when exactly one is raised
    logic          frc_hit;
    logic [IW-1:0] frc_idx;
    always_comb begin
        frc_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (force_i[i]) frc_idx = IW'(i);
        end
        frc_hit = ($countones(force_i) == 1) && elig[frc_idx];
    end

    // Primary decision for this tick
    logic          keep;
    logic          p_v;
    logic [IW-1:0] p_i;
    always_comb begin
        keep = !revert_i && st_q.pv && ok[st_q.pi];
        if (freerun_i) begin
            p_v = 1'b0;  p_i = '0;
        end else if (frc_hit) begin
            p_v = 1'b1;  p_i = frc_idx;
        end else if (keep) begin
            p_v = 1'b1;  p_i = st_q.pi;
        end else begin
            p_v = best_f; p_i = best_i;
        end
    end

    // Secondary candidates: qualifying, not primary, other slot pair
    for (genvar g = 0; g < N; g++) begin : g_sec
        assign pair[g]  = slot_i[g*SLW + SLW - 1];
        assign smask[g] = ok[g] && p_v && (p_i != IW'(g)) && (pair[g] != pair[p_i]);
    end

    logic          sec_f;
    logic [IW-1:0] sec_i;
    rcs_pick #(.N(N), .KW(KW)) u_pick_sec (
        .key_i(key), .mask_i(smask),
        .inc_valid_i(st_q.sv), .inc_idx_i(st_q.si),
        .found_o(sec_f), .idx_o(sec_i)
    );

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (tick_i) begin
            st_d.pv  = p_v;
            st_d.pi  = p_i;
            st_d.sv  = sec_f && !freerun_i;
            st_d.si  = (sec_f && !freerun_i) ? sec_i : '0;
            st_d.q   = p_v ? qsel[p_i*QW +: QW] : '0;
            st_d.fr  = freerun_i;
            st_d.upd = (st_d.pv != st_q.pv) || (st_d.pi != st_q.pi) ||
                       (st_d.sv != st_q.sv) || (st_d.si != st_q.si);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pri_idx_o   = st_q.pi;
    assign pri_valid_o = st_q.pv;
    assign sec_idx_o   = st_q.si;
    assign sec_valid_o = st_q.sv;
    assign qual_o      = st_q.q;
    assign freerun_o   = st_q.fr;
    assign upd_o       = st_q.upd;
endmodule

// File: rtl/rcs_chk.sv
`timescale 1ns/1ps
module rcs_chk
    import rcs_pkg::*;
#(
    parameter int N  = 8,
    parameter int QW = 3,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_i,
    input logic [N-1:0]     lock_i,
    input logic [N*SLW-1:0] slot_i,
    input logic [IW-1:0]    pri_idx_o,
    input logic             pri_valid_o,
    input logic [IW-1:0]    sec_idx_o,
    input logic             sec_valid_o,
    input logic [QW-1:0]    qual_o,
    input logic             freerun_o,
    input logic             upd_o
);
    // Candidate state seen at the last tick
    logic [N-1:0]     lock_cap;
    logic [N*SLW-1:0] slot_cap;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_cap <= '0;
            slot_cap <= '0;
        end else if (tick_i) begin
            lock_cap <= lock_i;
            slot_cap <= slot_i;
        end
    end

    logic pri_pair, sec_pair;
    assign pri_pair = slot_cap[pri_idx_o*SLW + SLW - 1];
    assign sec_pair = slot_cap[sec_idx_o*SLW + SLW - 1];

    AST_LOCK_PRI: assert property (@(posedge clk) disable iff (!rst_n)
        pri_valid_o |-> !lock_cap[pri_idx_o]); // R5
    AST_LOCK_SEC: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid_o |-> !lock_cap[sec_idx_o]); // R5
    AST_FREERUN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        freerun_o |-> (!pri_valid_o && !sec_valid_o && qual_o == '0)); // R8
    AST_SEC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sec_valid_o |-> (pri_valid_o && sec_idx_o != pri_idx_o && sec_pair != pri_pair)); // R9
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ($stable(pri_idx_o) && $stable(pri_valid_o) && $stable(sec_idx_o)
                     && $stable(sec_valid_o) && $stable(qual_o) && !upd_o)); // R10
    AST_DNU_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !pri_valid_o |-> (qual_o == '0)); // R11
endmodule

bind refclk_selector rcs_chk #(.N(N), .QW(QW)) u_rcs_chk (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .lock_i(lock_i), .slot_i(slot_i),
    .pri_idx_o(pri_idx_o), .pri_valid_o(pri_valid_o),
    .sec_idx_o(sec_idx_o), .sec_valid_o(sec_valid_o),
    .qual_o(qual_o), .freerun_o(freerun_o), .upd_o(upd_o)
);

// File: tb/test_refclk_selector.sv
`timescale 1ns/1ps
module test_refclk_selector;
    localparam int N = 8;
    localparam int QW = 3;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic tick = 1'b0;
    logic qmode = 1'b0, selrx = 1'b0, revert = 1'b1, freerun = 1'b0;
    logic       b_fail[N];
    logic       b_lock[N];
    logic       b_frc[N];
    logic [2:0] b_rx[N];
    logic [2:0] b_cfg[N];
    logic [2:0] b_prio[N];
    logic [1:0] b_kind[N];
    logic [1:0] b_slot[N];

    logic [N-1:0] fail_v, lock_v, frc_v;
    logic [N*QW-1:0] rx_v, cfg_v;
    logic [N*3-1:0] prio_v;
    logic [N*2-1:0] kind_v, slot_v;
    always_comb begin
        for (int i = 0; i < N; i++) begin
            fail_v[i] = b_fail[i];
            lock_v[i] = b_lock[i];
            frc_v[i]  = b_frc[i];
            rx_v[i*QW +: QW]  = b_rx[i];
            cfg_v[i*QW +: QW] = b_cfg[i];
            prio_v[i*3 +: 3]  = b_prio[i];
            kind_v[i*2 +: 2]  = b_kind[i];
            slot_v[i*2 +: 2]  = b_slot[i];
        end
    end

    logic [IW-1:0] pri_idx, sec_idx;
    logic pri_v, sec_v, fr, upd;
    logic [QW-1:0] qual;

    refclk_selector #(.N(N), .QW(QW)) i_refclk_selector (
        .clk(clk), .rst_n(rst_n), .tick_i(tick),
        .fail_i(fail_v), .rxq_i(rx_v), .cfgq_i(cfg_v), .prio_i(prio_v),
        .kind_i(kind_v), .slot_i(slot_v), .lock_i(lock_v), .force_i(frc_v),
        .qmode_i(qmode), .selrx_i(selrx), .revert_i(revert), .freerun_i(freerun),
        .pri_idx_o(pri_idx), .pri_valid_o(pri_v), .sec_idx_o(sec_idx),
        .sec_valid_o(sec_v), .qual_o(qual), .freerun_o(fr), .upd_o(upd)
    );

    int total = 0, bad = 0;
    bit finished = 0;

    // Expected state
    int e_pi = 0, e_si = 0, e_q = 0;
    bit e_pv = 0, e_sv = 0, e_fr = 0, e_upd = 0;

    task automatic chk(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit qualifies(int i);
        return !b_fail[i] && !b_lock[i] && (!qmode || b_rx[i] >= b_cfg[i]);
    endfunction

    function automatic int rank_q(int i);
        return (qmode && selrx) ? b_rx[i] : b_cfg[i];
    endfunction

    function automatic int pscore(int i);
        if (b_prio[i] >= 1 && b_prio[i] <= 5) return 8 - b_prio[i];
        if (b_kind[i] == 0) return 2;
        if (b_kind[i] == 1) return 1;
        return 0;
    endfunction

    function automatic int keyof(int i, bit inc);
        return (qmode ? rank_q(i) : 0) * 32 + pscore(i) * 2 + (inc ? 1 : 0);
    endfunction

    task automatic model();
        int fc = 0, fi = 0, best = -1, bk = -1, k;
        int n_pi = 0, n_si = 0;
        bit n_pv = 0, n_sv = 0;
        for (int i = 0; i < N; i++) if (b_frc[i]) begin fc++; fi = i; end
        if (!freerun) begin
            for (int i = 0; i < N; i++) begin
                if (qualifies(i)) begin
                    k = keyof(i, e_pv && e_pi == i);
                    if (k > bk) begin bk = k; best = i; end
                end
            end
            if (fc == 1 && !b_fail[fi] && !b_lock[fi]) begin n_pv = 1; n_pi = fi; end
            else if (!revert && e_pv && qualifies(e_pi)) begin n_pv = 1; n_pi = e_pi; end
            else if (best >= 0) begin n_pv = 1; n_pi = best; end
            if (n_pv) begin
                bk = -1;
                for (int j = 0; j < N; j++) begin
                    if (qualifies(j) && j != n_pi && b_slot[j][1] != b_slot[n_pi][1]) begin
                        k = keyof(j, e_sv && e_si == j);
                        if (k > bk) begin bk = k; n_si = j; n_sv = 1; end
                    end
                end
            end
        end
        e_upd = (n_pv != e_pv) || (n_pi != e_pi) || (n_sv != e_sv) || (n_si != e_si);
        e_pv = n_pv; e_pi = n_pi; e_sv = n_sv; e_si = n_si;
        e_q  = n_pv ? rank_q(n_pi) : 0;
        e_fr = freerun;
    endtask

    // Inputs are set at a falling edge before this call
    task automatic do_tick(string tag);
        model();
        tick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tick = 1'b0;
        chk({tag, " pri_valid"}, pri_v, e_pv);
        chk({tag, " pri_idx"}, pri_idx, e_pi);
        chk({tag, " sec_valid"}, sec_v, e_sv);
        chk({tag, " sec_idx"}, sec_idx, e_si);
        chk({tag, " qual"}, qual, e_q);
        chk({tag, " freerun"}, fr, e_fr);
        chk({tag, " R10 upd"}, upd, e_upd);
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) begin
            b_fail[i] = 1; b_lock[i] = 0; b_frc[i] = 0;
            b_rx[i] = 1; b_cfg[i] = 1; b_prio[i] = 0; b_kind[i] = 2;
            b_slot[i] = 2'(i / 2);
        end
        qmode = 0; selrx = 0; revert = 1; freerun = 0;
    endtask

    task automatic en(int i, int cfg, int rx);
        b_fail[i] = 0; b_cfg[i] = 3'(cfg); b_rx[i] = 3'(rx);
    endtask

    initial begin
        #1200000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        clear_all();
        repeat (3) @(negedge clk);
        // R12 reset state
        chk("R12 pri_valid", pri_v, 0);
        chk("R12 sec_valid", sec_v, 0);
        chk("R12 qual", qual, 0);
        chk("R12 upd", upd, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 best configured quality
        clear_all(); qmode = 1;
        en(2, 3, 7); en(5, 5, 7);
        do_tick("R1");
        chk("R1 primary", pri_idx, 5); chk("R1 qual", qual, 5);
        chk("R9 other pair", sec_idx, 2);

        // R4 received quality ranking, then disqualification
        selrx = 1; b_rx[5] = 5;
        do_tick("R4");
        chk("R4 rx rank primary", pri_idx, 2); chk("R4 qual", qual, 7);
        b_rx[2] = 2;
        do_tick("R4");
        chk("R4 rx below cfg", pri_idx, 5); chk("R4 no secondary", sec_v, 0);

        // R2 priority ordering with quality off
        clear_all();
        en(0, 1, 1); en(1, 1, 1); en(2, 1, 1);
        b_kind[0] = 2; b_kind[1] = 1; b_kind[2] = 0;
        do_tick("R2");
        chk("R2 ext A default", pri_idx, 2);
        b_prio[0] = 5;
        do_tick("R2");
        chk("R2 configured beats default", pri_idx, 0);
        b_prio[1] = 1;
        do_tick("R2");
        chk("R2 priority 1 strongest", pri_idx, 1);

        // R3 incumbency then lowest index
        clear_all();
        en(4, 1, 1);
        do_tick("R3");
        chk("R3 single", pri_idx, 4);
        en(3, 1, 1);
        do_tick("R3");
        chk("R3 incumbent kept", pri_idx, 4); chk("R3 secondary", sec_idx, 3);
        freerun = 1;
        do_tick("R8");
        chk("R8 freerun flag", fr, 1); chk("R8 pri invalid", pri_v, 0);
        chk("R8 qual dnu", qual, 0);
        freerun = 0;
        do_tick("R3");
        chk("R3 lowest index", pri_idx, 3);

        // R5 lockout
        clear_all(); qmode = 1;
        en(2, 7, 7); en(6, 3, 3); b_lock[2] = 1;
        do_tick("R5");
        chk("R5 locked skipped", pri_idx, 6); chk("R5 not secondary", sec_v, 0);

        // R6 force switch
        clear_all(); qmode = 1;
        en(0, 7, 7); en(3, 1, 1); b_frc[3] = 1;
        do_tick("R6");
        chk("R6 forced", pri_idx, 3);
        b_frc[5] = 1;
        do_tick("R6");
        chk("R6 two requests ignored", pri_idx, 0);
        b_frc[5] = 0; b_lock[3] = 1;
        do_tick("R6");
        chk("R6 locked force ignored", pri_idx, 0);

        // R7 non-revertive hold, then revert
        clear_all(); qmode = 1; revert = 0;
        en(1, 2, 2);
        do_tick("R7");
        en(6, 7, 7);
        do_tick("R7");
        chk("R7 hold", pri_idx, 1); chk("R7 sec", sec_idx, 6);
        revert = 1;
        do_tick("R7");
        chk("R7 revert", pri_idx, 6);

        // R9 pair restriction
        clear_all(); qmode = 1;
        en(0, 7, 7); en(1, 6, 6); en(4, 3, 3);
        do_tick("R9");
        chk("R9 primary", pri_idx, 0); chk("R9 secondary other pair", sec_idx, 4);

        // R10 no tick: inputs change, outputs hold
        b_lock[0] = 1; en(5, 7, 7);
        repeat (3) @(negedge clk);
        chk("R10 hold pri", pri_idx, 0); chk("R10 hold sec", sec_idx, 4);
        chk("R10 no pulse", upd, 0);

        // R11 nothing qualifies
        clear_all(); qmode = 1;
        do_tick("R11");
        chk("R11 pri invalid", pri_v, 0); chk("R11 dnu", qual, 0);

        // Random R1/R2/R3/R4/R6/R7/R9 against the model
        for (int t = 0; t < 600; t++) begin
            for (int i = 0; i < N; i++) begin
                b_fail[i] = ($urandom % 4) == 0;
                b_lock[i] = ($urandom % 8) == 0;
                b_frc[i]  = ($urandom % 24) == 0;
                b_rx[i]   = 3'(3 + $urandom % 3);
                b_cfg[i]  = 3'(2 + $urandom % 3);
                b_prio[i] = 3'($urandom % 7);
                b_kind[i] = 2'($urandom % 4);
                b_slot[i] = 2'($urandom % 4);
            end
            qmode = $urandom % 2; selrx = $urandom % 2;
            revert = $urandom % 2; freerun = ($urandom % 10) == 0;
            do_tick("R1/R3/R7/R9 random");
            if ((t % 5) == 0) @(negedge clk);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule